// File: doc/BRIEF.md
# Basic-block instruction hash checker

The checker takes the instruction words a processor executes and groups them into basic blocks. The processor marks the last word of each block with a strobe. On that same word it also supplies a 32-bit reference tag, which was computed offline for the block. The words pass through a 16-entry queue into a packer. The packer builds one SHA-1 message block of 512 bits, with the usual padding: a single 1 bit, zero fill, and the bit length of the message in the final word. A compression core then runs the 80 rounds, one per clock, from the standard initial chaining values.

The core works while the processor keeps issuing words. The processor is held back only when the queue is full. When a block finishes, only the top 32 bits of the digest are compared with the tag. These bits are the final A word plus its initial value. A mismatch sets a sticky alarm that stays set until reset. A block of more than 13 words does not fit in one padded message. Such a block is reported as a failed block and is not hashed.

Top module: `instr_hash_checker`

## Requirements
- R1: After reset, `stall`, `blk_done`, `blk_ok` and `invalid` are all 0.
- R2: For a block of n words (1 ≤ n ≤ 13), the value compared is bits 159..128 of the SHA-1 digest of a single 512-bit message block. In that message block, word i (i < n) is instruction word i, word n is 0x80000000, words n+1 to 14 are 0, and word 15 is n*32. Example: the one-word block 0x61626364 gives 0x81fe8bfe.
- R3: When the 32-bit reference tag given with the last word equals the compared digest bits, `blk_ok` is 1 in the `blk_done` cycle, and `invalid` stays 0.
- R4: When the tag differs in any bit, `blk_ok` is 0 in the `blk_done` cycle. `invalid` then becomes 1 and stays 1 until reset, even after later blocks that match.
- R5: The `ref_tag` value presented with words that are not the last word of a block has no effect on the result.
- R6: `stall` is 1 exactly when 16 words are queued. A word offered while `stall` is 1 is not taken, and no accepted word is lost or reordered.
- R7: Every block length from 1 to 13 words is hashed and checked.
- R8: A block of more than 13 words gives `blk_done` with `blk_ok` = 0 and sets `invalid`.
- R9: Each block produces exactly one one-cycle `blk_done` pulse. The pulses come in the order in which the blocks were issued.
- R10: While fewer than 16 words are queued, `stall` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction word is offered |
| instr_word | input | 32 | Executed instruction word |
| instr_last | input | 1 | The word ends its basic block |
| ref_tag | input | 32 | Precomputed tag; used only when `instr_last` is 1 |
| stall | output | 1 | Queue full; hold the offered word |
| blk_done | output | 1 | One-cycle pulse: the result of a block is ready |
| blk_ok | output | 1 | The block's tag matched (valid with `blk_done`) |
| invalid | output | 1 | Sticky integrity alarm |

## Verification
Most internal faults show up in the comparison itself:
- A wrong round function, constant, schedule tap or padding word changes the 32 compared bits. The first `blk_done` after the fault therefore reports the wrong match result, about 82 cycles after the last word is taken.
- A wrong packer count either misplaces the length word or misjudges an overlong block. This shows up on the next block's result.

Queue faults show up in different ways:
- A corrupted queue pointer or occupancy count appears as a `stall` at the wrong time.
- Such a fault can also lose or reorder words. Later blocks then mismatch and `blk_done` pulses go missing or come in the wrong order.

The bench detects these cases with a back-to-back burst and an independent SHA-1 model.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

  localparam logic [31:0] IV_A = 32'h67452301;
  localparam logic [31:0] IV_B = 32'hEFCDAB89;
  localparam logic [31:0] IV_C = 32'h98BADCFE;
  localparam logic [31:0] IV_D = 32'h10325476;
  localparam logic [31:0] IV_E = 32'hC3D2E1F0;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int unsigned n);
    rotl = (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] mix_fn(input logic [6:0] t, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] d);
    if (t < 7'd20)      mix_fn = (b & c) | (~b & d);
    else if (t < 7'd40) mix_fn = b ^ c ^ d;
    else if (t < 7'd60) mix_fn = (b & c) | (b & d) | (c & d);
    else                mix_fn = b ^ c ^ d;
  endfunction

  function automatic logic [31:0] round_const(input logic [6:0] t);
    if (t < 7'd20)      round_const = 32'h5A827999;
    else if (t < 7'd40) round_const = 32'h6ED9EBA1;
    else if (t < 7'd60) round_const = 32'h8F1BBCDC;
    else                round_const = 32'hCA62C1D6;
  endfunction

  function automatic logic [31:0] next_a(input logic [6:0] t, input logic [31:0] a,
                                         input logic [31:0] b, input logic [31:0] c,
                                         input logic [31:0] d, input logic [31:0] e,
                                         input logic [31:0] w);
    next_a = rotl(a, 5) + mix_fn(t, b, c, d) + e + round_const(t) + w;
  endfunction

  // Word idx of the padded message whose data length is len words; data is the
  // candidate instruction word for that slot.
  function automatic logic [31:0] pad_word(input int unsigned idx, input int unsigned len,
                                           input logic [31:0] data);
    if (idx == 15)           pad_word = 32'(len * 32);
    else if (idx < len)      pad_word = data;
    else if (idx == len)     pad_word = 32'h8000_0000;
    else                     pad_word = 32'h0;
  endfunction

endpackage

// File: rtl/ihc_fifo.sv
module ihc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    inc_ptr = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= inc_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= inc_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (count <= CW'(DEPTH)));
  assert_push_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> (count <= CW'(DEPTH)) && !(empty && $past(do_pop)));
endmodule

// File: rtl/ihc_packer.sv
module ihc_packer #(
  parameter int MAX_WORDS = 13,
  parameter int TAG_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  logic [31:0]      q_word,
  input  logic             q_last,
  input  logic [TAG_W-1:0] q_tag,
  input  logic             core_busy,
  output logic             q_pop,
  output logic             start,
  output logic             overlong_evt,
  output logic [511:0]     msg,
  output logic [TAG_W-1:0] tag
);
  import ihc_pkg::*;
  localparam int CNT_W = $clog2(MAX_WORDS + 2);

  logic [31:0]      buf_q [16];
  logic [CNT_W-1:0] cnt_q;
  logic             take_last, take_body, too_long;

  // A last word waits at the head until the core is free.
  assign q_pop        = !q_empty && !(q_last && core_busy);
  assign take_last    = q_pop && q_last;
  assign take_body    = q_pop && !q_last;
  assign too_long     = (cnt_q >= CNT_W'(MAX_WORDS));
  assign start        = take_last && !too_long;
  assign overlong_evt = take_last && too_long;
  assign tag          = q_tag;

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      msg[511 - 32*i -: 32] = pad_word(i, int'(cnt_q) + 1,
                                       (i == int'(cnt_q)) ? q_word : buf_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (take_last) begin
      cnt_q <= '0;
    end else if (take_body && cnt_q <= CNT_W'(MAX_WORDS)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_body && cnt_q < CNT_W'(MAX_WORDS)) buf_q[cnt_q[3:0]] <= q_word;
  end

  assert_start_xor_over_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && overlong_evt));
  assert_start_needs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start || overlong_evt) |-> !core_busy);
endmodule

// File: rtl/ihc_sha1_core.sv
module ihc_sha1_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [511:0] msg,
  output logic         busy,
  output logic         done,
  output logic [159:0] digest
);
  import ihc_pkg::*;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} core_st_e;

  core_st_e    st;
  logic [6:0]  rnd;
  logic [31:0] a, b, c, d, e;
  logic [31:0] win [16];
  logic [31:0] sched_new;
  logic        last_round;

  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_FIN);
  assign last_round = (st == ST_RUN) && (rnd == 7'd79);
  assign sched_new  = rotl(win[13] ^ win[8] ^ win[2] ^ win[0], 1);
  assign digest     = {a + IV_A, b + IV_B, c + IV_C, d + IV_D, e + IV_E};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      rnd <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin st <= ST_RUN; rnd <= '0; end
        ST_RUN:  begin
          rnd <= rnd + 1'b1;
          if (last_round) st <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_IDLE && start) begin
      a <= IV_A; b <= IV_B; c <= IV_C; d <= IV_D; e <= IV_E;
      for (int i = 0; i < 16; i++) win[i] <= msg[511 - 32*i -: 32];
    end else if (st == ST_RUN) begin
      a <= next_a(rnd, a, b, c, d, e, win[0]);
      b <= a;
      c <= rotl(b, 30);
      d <= c;
      e <= d;
      for (int i = 0; i < 15; i++) win[i] <= win[i + 1];
      win[15] <= sched_new;
    end
  end

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_fin_after_80_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> done);
endmodule

// File: rtl/instr_hash_checker.sv
module instr_hash_checker #(
  parameter int DEPTH     = 16,
  parameter int MAX_WORDS = 13,
  parameter int TAG_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [31:0]      instr_word,
  input  logic             instr_last,
  input  logic [TAG_W-1:0] ref_tag,
  output logic             stall,
  output logic             blk_done,
  output logic             blk_ok,
  output logic             invalid
);
  localparam int ENT_W = 1 + 32 + TAG_W;

  logic [ENT_W-1:0] q_din, q_dout;
  logic             q_empty, q_full, q_pop;
  logic             core_busy, core_done, pk_start, pk_over;
  logic [511:0]     pk_msg;
  logic [TAG_W-1:0] pk_tag, tag_q;
  logic [159:0]     core_digest;
  logic             tag_hit;

  assign q_din   = {instr_last, instr_word, instr_last ? ref_tag : {TAG_W{1'b0}}};
  assign stall   = q_full;
  assign tag_hit = (core_digest[159 -: TAG_W] == tag_q);

  ihc_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(instr_valid), .din(q_din),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  ihc_packer #(.MAX_WORDS(MAX_WORDS), .TAG_W(TAG_W)) u_packer (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty),
    .q_word(q_dout[TAG_W +: 32]), .q_last(q_dout[ENT_W-1]), .q_tag(q_dout[TAG_W-1:0]),
    .core_busy(core_busy), .q_pop(q_pop), .start(pk_start), .overlong_evt(pk_over),
    .msg(pk_msg), .tag(pk_tag)
  );

  ihc_sha1_core u_core (
    .clk(clk), .rst_n(rst_n), .start(pk_start), .msg(pk_msg),
    .busy(core_busy), .done(core_done), .digest(core_digest)
  );

  always_ff @(posedge clk) begin
    if (pk_start) tag_q <= pk_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_done <= 1'b0;
      blk_ok   <= 1'b0;
      invalid  <= 1'b0;
    end else begin
      blk_done <= core_done || pk_over;
      blk_ok   <= core_done && tag_hit;
      if ((core_done && !tag_hit) || pk_over) invalid <= 1'b1;
    end
  end

  assert_invalid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |=> invalid);
  assert_ok_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ok |-> blk_done);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);
  assert_fail_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !blk_ok) |-> invalid);
endmodule

// File: tb/tb_instr_hash_checker.sv
module tb_instr_hash_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        instr_last = 1'b0;
  logic [31:0] ref_tag = '0;
  logic        stall, blk_done, blk_ok, invalid;

  int n_checks = 0;
  int n_fail = 0;
  int n_res = 0;
  logic res_ok [0:63];
  logic stall_seen = 1'b0;
  logic [31:0] wbuf [0:15];

  always #10 clk = ~clk;

  instr_hash_checker dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_last(instr_last), .ref_tag(ref_tag), .stall(stall),
    .blk_done(blk_done), .blk_ok(blk_ok), .invalid(invalid)
  );

  always @(negedge clk) begin
    if (rst_n && blk_done) begin
      if (n_res < 64) res_ok[n_res] = blk_ok;
      n_res = n_res + 1;
    end
    if (stall) stall_seen = 1'b1;
  end

  task automatic check(input logic cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  // Independent SHA-1 of n words from wbuf, returning the top 32 digest bits.
  function automatic logic [31:0] model_top(input int n);
    logic [31:0] w [0:79];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) begin
      if (i < n) w[i] = wbuf[i];
      else if (i == n) w[i] = 32'h80000000;
      else if (i == 15) w[i] = n * 32;
      else w[i] = 0;
    end
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int i = 0; i < 80; i++) begin
      case (i / 20)
        0: begin f = d ^ (b & (c ^ d)); k = 32'h5A827999; end
        1: begin f = b ^ c ^ d; k = 32'h6ED9EBA1; end
        2: begin f = (b & c) ^ (b & d) ^ (c & d); k = 32'h8F1BBCDC; end
        default: begin f = b ^ c ^ d; k = 32'hCA62C1D6; end
      endcase
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return a + 32'h67452301;
  endfunction

  function automatic logic [31:0] gen(input int s);
    return (32'h9E3779B9 * (s + 1)) ^ (s << 7) ^ 32'h13;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; instr_valid = 1'b0; instr_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_res = 0;
    stall_seen = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input logic last, input logic [31:0] tg);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w; instr_last = last; ref_tag = tg;
    while (stall) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    instr_valid = 1'b0; instr_last = 1'b0;
  endtask

  // Sends n words from wbuf; junk tags ride on non-last words (R5).
  task automatic send_block(input int n, input logic [31:0] tg);
    for (int i = 0; i < n; i++)
      send_word(wbuf[i], i == n - 1, (i == n - 1) ? tg : ~tg ^ i);
  endtask

  task automatic wait_results(input int want);
    int guard = 0;
    while (n_res < want && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    check(n_res >= want, "R9 result count", n_res, want);
  endtask

  task automatic t_reset();
    do_reset();
    check(stall == 0 && blk_done == 0 && blk_ok == 0 && invalid == 0, "R1 reset outputs",
          {stall, blk_done, blk_ok, invalid}, 0);
  endtask

  task automatic t_known();
    do_reset();
    wbuf[0] = 32'h61626364;
    check(model_top(1) == 32'h81fe8bfe, "R2 model known answer", model_top(1), 32'h81fe8bfe);
    send_block(1, 32'h81fe8bfe);
    go_idle();
    wait_results(1);
    check(res_ok[0] == 1'b1, "R2 R3 known block matches", res_ok[0], 1);
    check(invalid == 1'b0, "R3 no alarm on match", invalid, 0);
    repeat (4) @(negedge clk);
    check(n_res == 1, "R9 single done pulse", n_res, 1);
    check(stall_seen == 1'b0, "R10 no stall for short block", stall_seen, 0);
  endtask

  task automatic t_mismatch();
    do_reset();
    wbuf[0] = 32'h61626364;
    send_block(1, 32'h81fe8bff);
    go_idle();
    wait_results(1);
    check(res_ok[0] == 1'b0, "R4 one-bit tag mismatch", res_ok[0], 0);
    check(invalid == 1'b1, "R4 alarm raised", invalid, 1);
    send_block(1, 32'h81fe8bfe);
    go_idle();
    wait_results(2);
    check(res_ok[1] == 1'b1 && invalid == 1'b1, "R4 alarm sticky after match",
          {res_ok[1], invalid}, 2'b11);
  endtask

  task automatic t_lengths();
    do_reset();
    for (int n = 1; n <= 13; n++) begin
      for (int i = 0; i < n; i++) wbuf[i] = gen(n * 16 + i);
      send_block(n, model_top(n));
    end
    go_idle();
    wait_results(13);
    for (int n = 1; n <= 13; n++)
      check(res_ok[n-1] == 1'b1, $sformatf("R7 R5 R2 length %0d", n), res_ok[n-1], 1);
    check(invalid == 1'b0, "R7 no alarm over all lengths", invalid, 0);
  endtask

  task automatic t_overlong();
    do_reset();
    for (int i = 0; i < 14; i++) send_word(gen(i), i == 13, 32'h0);
    go_idle();
    wait_results(1);
    check(res_ok[0] == 1'b0 && invalid == 1'b1, "R8 fourteen-word block rejected",
          {res_ok[0], invalid}, 2'b01);
    wbuf[0] = 32'h61626364;
    send_block(1, 32'h81fe8bfe);
    go_idle();
    wait_results(2);
    check(res_ok[1] == 1'b1, "R8 next block still hashed", res_ok[1], 1);
  endtask

  task automatic t_burst();
    logic [31:0] tg;
    do_reset();
    for (int j = 0; j < 20; j++) begin
      wbuf[0] = gen(100 + j);
      tg = model_top(1);
      if (j % 3 == 2) tg = tg ^ 32'h0001_0000;
      send_word(wbuf[0], 1'b1, tg);
    end
    go_idle();
    check(stall_seen == 1'b1, "R6 stall when queue full", stall_seen, 1);
    wait_results(20);
    for (int j = 0; j < 20; j++)
      check(res_ok[j] == (j % 3 != 2), $sformatf("R6 R9 burst block %0d order", j),
            res_ok[j], (j % 3 != 2));
    check(stall == 1'b0, "R10 stall released when drained", stall, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_mismatch();
    t_lengths();
    t_overlong();
    t_burst();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule